// File: doc/BRIEF.md
# Configurable Waveform-Mode Timer/Counter

This block is a 16-bit timer/counter whose counting shape is chosen by a 4-bit mode number held in two control registers. The mode sets four things. The first is whether the counter only counts up and wraps, or runs up to a ceiling and back down. The second is where the ceiling (TOP) comes from: a fixed 8, 9, 10 or 16-bit limit, the channel A compare register, or a capture register. The third is the point at which written compare values take effect. The fourth is the point at which the overflow pulse fires.

A clock-select field gates counting through a free-running prescaler. Two compare channels raise one-cycle match pulses, and each drives a waveform output whose behaviour is set by a 2-bit output mode. Software reaches every register through a single-cycle write port. The counter value is always visible on an output.

Register addresses on `wrAddr`:

- 0: control A. Bits 1:0 are mode bits 1:0. Bits 5:4 are the output mode of channel B. Bits 7:6 are the output mode of channel A.
- 1: control B. Bits 2:0 are the clock select. Bits 4:3 are mode bits 3:2.
- 2: counter.
- 3: compare A.
- 4: compare B.
- 5: capture value.

Top module: `wfm_timer`

## Requirements
- R1: After reset, the counter is 0, the match and overflow pulses are 0, and both waveform outputs are 0.
- R2: Clock select 0 stops the counter. Values 6 and 7 also count nothing, and the counter holds its value.
- R3: Clock select 1 counts every cycle. Clock select 2 counts once every 8 cycles, and clock select 3 counts once every 64 cycles. Clock selects 4 and 5 count once every 256 and every 1024 cycles.
- R4: Modes 0 and 13 count up from 0 to 0xFFFF and wrap to 0. The overflow pulse is high in the cycle in which the counter shows 0 after leaving 0xFFFF.
- R5: Mode 4 counts up to the active compare A value and then clears to 0. In this mode, compare writes take effect on the next cycle. The channel A match pulse is high for exactly the cycle in which the counter shows the compare A value, and no overflow pulse fires below 0xFFFF.
- R6: Modes 5, 6 and 7 count up to 0xFF, 0x1FF and 0x3FF and wrap to 0, with the overflow pulse in the wrap cycle. With output mode 2, the waveform output goes to 1 on the wrap to 0 and goes to 0 on a compare match.
- R7: Modes 1, 2 and 3 count from 0 up to the fixed TOP (0xFF, 0x1FF or 0x3FF) and then back down. The overflow pulse fires in the cycle in which the counter turns from 0 back up to 1. It does not fire at TOP, and it does not fire on arriving at 0.
- R8: The update point depends on the mode family. In phase-correct modes, a compare write is held in a buffer and becomes active only when the counter reaches TOP. Until then, matches use the old value.
- R9: Mode 12 counts up to the capture register value and then clears to 0.
- R10: A write to the counter overrides any count or clear in the same cycle, so the counter shows the written value. A write never raises a match pulse.
- R11: The channel B match pulse is high for exactly the cycle in which the counter shows the active compare B value.
- R12: With output mode 1, the waveform output toggles on each compare match. Output mode 0 holds it at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register address |
| wrData | input | 16 | Write data (the control registers take the low 8 bits) |
| cntOut | output | 16 | Current counter value |
| ocfA | output | 1 | Channel A compare match pulse |
| ocfB | output | 1 | Channel B compare match pulse |
| tovPulse | output | 1 | Overflow pulse |
| ocAOut | output | 1 | Channel A waveform output |
| ocBOut | output | 1 | Channel B waveform output |

## Verification
The bench targets the turnaround points.

- At the top of a phase-correct sweep, a design that wrapped instead of reversing would show 0 after 0xFF. One that flagged overflow at TOP or on arriving at 0 would pulse one cycle early.
- For compare buffering, a design that loaded the new value at once would match on the way up, where the old value must still match.
- For the CTC and capture-limited modes, a design that compared against the raw limit instead of the active one would run past it.
- A write to the counter in the same cycle as a tick is checked so that a design that let the count win, or that raised a match on written values, is exposed.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int CNT_W = 16;

  localparam logic [2:0] ADDR_CTLA = 3'd0;
  localparam logic [2:0] ADDR_CTLB = 3'd1;
  localparam logic [2:0] ADDR_CNT  = 3'd2;
  localparam logic [2:0] ADDR_CMPA = 3'd3;
  localparam logic [2:0] ADDR_CMPB = 3'd4;
  localparam logic [2:0] ADDR_CAP  = 3'd5;

  typedef enum logic [1:0] {SHP_UP, SHP_FAST, SHP_DUAL} shape_e;
  typedef enum logic [1:0] {TOP_FIX, TOP_CMPA, TOP_CAP} topSrc_e;
  typedef enum logic [1:0] {UPD_NOW, UPD_TOP, UPD_BOT} updPt_e;
  typedef enum logic [1:0] {OVF_MAX, OVF_TOP, OVF_BOT} ovfPt_e;

  typedef struct packed {
    logic             tick;
    shape_e           shape;
    topSrc_e          topSrc;
    logic [CNT_W-1:0] topFix;
    updPt_e           updPt;
    ovfPt_e           ovfPt;
    logic [1:0]       comA;
    logic [1:0]       comB;
  } strobe_t;

  // Mode number to counting behaviour
  function automatic strobe_t decodeMode(logic [3:0] mode);
    strobe_t s;
    s = '0;
    s.shape  = SHP_UP;
    s.topSrc = TOP_FIX;
    s.topFix = '1;
    s.updPt  = UPD_NOW;
    s.ovfPt  = OVF_MAX;
    case (mode)
      4'd1, 4'd2, 4'd3: begin
        s.shape = SHP_DUAL; s.updPt = UPD_TOP; s.ovfPt = OVF_BOT;
        s.topFix = CNT_W'((32'd1 << (7 + int'(mode[1:0]))) - 32'd1);
      end
      4'd4:  s.topSrc = TOP_CMPA;
      4'd5, 4'd6, 4'd7: begin
        s.shape = SHP_FAST; s.updPt = UPD_BOT; s.ovfPt = OVF_TOP;
        s.topFix = CNT_W'((32'd1 << (7 + int'(mode[1:0]))) - 32'd1);
      end
      4'd8:  begin s.shape = SHP_DUAL; s.topSrc = TOP_CAP;  s.updPt = UPD_BOT; s.ovfPt = OVF_BOT; end
      4'd9:  begin s.shape = SHP_DUAL; s.topSrc = TOP_CMPA; s.updPt = UPD_BOT; s.ovfPt = OVF_BOT; end
      4'd10: begin s.shape = SHP_DUAL; s.topSrc = TOP_CAP;  s.updPt = UPD_TOP; s.ovfPt = OVF_BOT; end
      4'd11: begin s.shape = SHP_DUAL; s.topSrc = TOP_CMPA; s.updPt = UPD_TOP; s.ovfPt = OVF_BOT; end
      4'd12: s.topSrc = TOP_CAP;
      4'd14: begin s.shape = SHP_FAST; s.topSrc = TOP_CAP;  s.updPt = UPD_BOT; s.ovfPt = OVF_TOP; end
      4'd15: begin s.shape = SHP_FAST; s.topSrc = TOP_CMPA; s.updPt = UPD_BOT; s.ovfPt = OVF_TOP; end
      default: ;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int DIV_LOG_MAX = 10
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [2:0] wrAddr,
  input  logic [7:0] wrByte,
  output strobe_t    st
);
  logic [7:0]             ctlA, ctlB;
  logic [DIV_LOG_MAX-1:0] presc;
  logic [2:0]             cs;
  logic [3:0]             mode;
  logic                   tick;

  assign cs   = ctlB[2:0];
  assign mode = {ctlB[4:3], ctlA[1:0]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctlA  <= '0;
      ctlB  <= '0;
      presc <= '0;
    end else begin
      presc <= presc + 1'b1;
      if (wrEn && wrAddr == ADDR_CTLA) ctlA <= wrByte;
      if (wrEn && wrAddr == ADDR_CTLB) ctlB <= wrByte;
    end
  end

  always_comb begin
    case (cs)
      3'd1:    tick = 1'b1;
      3'd2:    tick = &presc[2:0];
      3'd3:    tick = &presc[5:0];
      3'd4:    tick = &presc[7:0];
      3'd5:    tick = &presc[DIV_LOG_MAX-1:0];
      default: tick = 1'b0;
    endcase
  end

  always_comb begin
    st      = decodeMode(mode);
    st.tick = tick;
    st.comA = ctlA[7:6];
    st.comB = ctlA[5:4];
  end

  // R2: a count enable only ever comes from a divider selection
  assert_tick_cs_R2: assert property (@(posedge clk) disable iff (!rstN)
    st.tick |-> (cs != 3'd0 && cs < 3'd6));
endmodule

// File: rtl/tmr_dp.sv
module tmr_dp
  import tmr_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [2:0]       wrAddr,
  input  logic [CNT_W-1:0] wrData,
  input  strobe_t          st,
  output logic [CNT_W-1:0] cnt,
  output logic             ocfA,
  output logic             ocfB,
  output logic             tov,
  output logic             ocA,
  output logic             ocB
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic             dirUp, nxtDir, cntWr;
  logic [CNT_W-1:0] bufA, bufB, actA, actB, icr, top, nxtCnt;
  logic             atTop, topEvt, botEvt, maxEvt, loadEvt, ovfEvt;
  logic             hitA, hitB, wrapSet;

  assign cntWr = wrEn && wrAddr == ADDR_CNT;

  always_comb begin
    case (st.topSrc)
      TOP_CMPA: top = actA;
      TOP_CAP:  top = icr;
      default:  top = st.topFix;
    endcase
  end

  assign atTop  = (st.shape == SHP_DUAL) ? (dirUp && cnt >= top) : (cnt == top);
  assign topEvt = st.tick && atTop;
  assign botEvt = (st.shape == SHP_DUAL) ? (st.tick && !dirUp && cnt == '0) : topEvt;
  assign maxEvt = st.tick && st.shape != SHP_DUAL && cnt == '1;

  always_comb begin
    nxtCnt = cnt;
    nxtDir = (st.shape == SHP_DUAL) ? dirUp : 1'b1;
    if (st.tick) begin
      if (st.shape == SHP_DUAL) begin
        if (dirUp && cnt >= top) begin
          nxtDir = 1'b0;
          nxtCnt = (cnt == '0) ? '0 : cnt - ONE;
        end else if (!dirUp && cnt == '0) begin
          nxtDir = 1'b1;
          nxtCnt = (top == '0) ? '0 : ONE;
        end else begin
          nxtCnt = dirUp ? cnt + ONE : cnt - ONE;
        end
      end else begin
        nxtCnt = atTop ? '0 : cnt + ONE;
      end
    end
  end

  always_comb begin
    case (st.updPt)
      UPD_TOP: loadEvt = topEvt;
      UPD_BOT: loadEvt = botEvt;
      default: loadEvt = 1'b1;
    endcase
    case (st.ovfPt)
      OVF_TOP: ovfEvt = topEvt;
      OVF_BOT: ovfEvt = botEvt;
      default: ovfEvt = maxEvt;
    endcase
  end

  assign hitA    = st.tick && !cntWr && nxtCnt == actA;
  assign hitB    = st.tick && !cntWr && nxtCnt == actB;
  assign wrapSet = topEvt && !cntWr && st.shape == SHP_FAST;

  function automatic logic waveNext(logic cur, logic [1:0] com, logic hit,
                                    logic wrap, shape_e shp, logic upNext);
    logic v;
    v = cur;
    if (com == 2'd0) v = 1'b0;
    else if (com == 2'd1) begin
      if (hit) v = ~cur;
    end else begin
      if (wrap) v = (com == 2'd2);
      if (hit) begin
        if (shp == SHP_DUAL) v = (com == 2'd2) ? ~upNext : upNext;
        else                 v = (com == 2'd3);
      end
    end
    return v;
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= '0; dirUp <= 1'b1;
      bufA <= '0; bufB <= '0; actA <= '0; actB <= '0; icr <= '0;
      ocfA <= 1'b0; ocfB <= 1'b0; tov <= 1'b0; ocA <= 1'b0; ocB <= 1'b0;
    end else begin
      cnt   <= cntWr ? wrData : nxtCnt;
      dirUp <= nxtDir;
      if (wrEn && wrAddr == ADDR_CMPA) bufA <= wrData;
      if (wrEn && wrAddr == ADDR_CMPB) bufB <= wrData;
      if (wrEn && wrAddr == ADDR_CAP)  icr  <= wrData;
      if (wrEn && wrAddr == ADDR_CMPA && st.updPt == UPD_NOW) actA <= wrData;
      else if (loadEvt) actA <= bufA;
      if (wrEn && wrAddr == ADDR_CMPB && st.updPt == UPD_NOW) actB <= wrData;
      else if (loadEvt) actB <= bufB;
      ocfA <= hitA;
      ocfB <= hitB;
      tov  <= ovfEvt;
      ocA  <= waveNext(ocA, st.comA, hitA, wrapSet, st.shape, nxtDir);
      ocB  <= waveNext(ocB, st.comB, hitB, wrapSet, st.shape, nxtDir);
    end
  end

  // R2: without a count enable or a write, the counter holds
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!st.tick && !cntWr) |=> $stable(cnt));
  // R10: a counter write always lands, whatever the count logic wanted
  assert_wr_prio_R10: assert property (@(posedge clk) disable iff (!rstN)
    cntWr |=> (cnt == $past(wrData)));
  // R5: a match pulse coincides with the counter showing the compare value
  assert_match_a_R5: assert property (@(posedge clk) disable iff (!rstN)
    ocfA |-> (cnt == $past(actA)));
  // R7: in dual-slope shapes the counter moves by at most one step
  assert_dual_step_R7: assert property (@(posedge clk) disable iff (!rstN)
    (st.shape == SHP_DUAL && !cntWr) |=>
      ((cnt - $past(cnt)) inside {CNT_W'(0), CNT_W'(1), {CNT_W{1'b1}}}));
endmodule

// File: rtl/wfm_timer.sv
module wfm_timer
  import tmr_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [2:0]       wrAddr,
  input  logic [CNT_W-1:0] wrData,
  output logic [CNT_W-1:0] cntOut,
  output logic             ocfA,
  output logic             ocfB,
  output logic             tovPulse,
  output logic             ocAOut,
  output logic             ocBOut
);
  strobe_t st;

  tmr_ctrl #(.DIV_LOG_MAX(10)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrByte(wrData[7:0]), .st(st)
  );

  tmr_dp u_dp (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .st(st), .cnt(cntOut), .ocfA(ocfA), .ocfB(ocfB), .tov(tovPulse),
    .ocA(ocAOut), .ocB(ocBOut)
  );
endmodule

// File: tb/wfm_timer_bench.sv
module wfm_timer_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrAddr = '0;
  logic [15:0] wrData = '0;
  logic [15:0] cntOut;
  logic        ocfA, ocfB, tovPulse, ocAOut, ocBOut;
  int          nChk = 0;
  int          nFail = 0;

  always #4 clk = ~clk;

  wfm_timer u_wfm_timer (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .cntOut(cntOut), .ocfA(ocfA), .ocfB(ocfB), .tovPulse(tovPulse),
    .ocAOut(ocAOut), .ocBOut(ocBOut)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic runTo(logic [15:0] v, int lim);
    for (int i = 0; i < lim && cntOut != v; i++) step();
  endtask

  task automatic t_reset();
    chk("R1 cnt", cntOut, 0);
    chk("R1 flags", {ocfA, ocfB, tovPulse}, 0);
    chk("R1 waves", {ocAOut, ocBOut}, 0);
  endtask

  task automatic t_stop();
    wr(0, 16'h00); wr(1, 16'h00); wr(2, 16'd5);
    repeat (5) step();
    chk("R2 cs0 holds", cntOut, 5);
    wr(1, 16'h06);
    repeat (20) step();
    chk("R2 cs6 holds", cntOut, 5);
    wr(1, 16'h07);
    repeat (20) step();
    chk("R2 cs7 holds", cntOut, 5);
  endtask

  task automatic measure(logic [15:0] ctl, int exp, string req);
    logic [15:0] c0;
    int n;
    wr(1, ctl);
    c0 = cntOut;
    for (int i = 0; i < 2100 && cntOut == c0; i++) step();
    c0 = cntOut;
    n = 0;
    for (int i = 0; i < 2100 && cntOut == c0; i++) begin step(); n++; end
    chk(req, n, exp);
  endtask

  task automatic t_presc();
    measure(16'h02, 8, "R3 div8");
    measure(16'h03, 64, "R3 div64");
    measure(16'h04, 256, "R3 div256");
    wr(1, 16'h00);
  endtask

  task automatic t_normal();
    wr(1, 16'h01); wr(2, 16'hFFFD);
    chk("R10 write value", cntOut, 16'hFFFD);
    step(); chk("R4 step", cntOut, 16'hFFFE);
    step(); chk("R4 max", cntOut, 16'hFFFF); chk("R4 no early ovf", tovPulse, 0);
    step(); chk("R4 wrap", cntOut, 0);       chk("R4 ovf at max", tovPulse, 1);
    step(); chk("R4 ovf one cycle", tovPulse, 0);
  endtask

  task automatic t_chanB();
    wr(1, 16'h00); wr(0, 16'h10); wr(1, 16'h01); wr(4, 16'd5); wr(2, 16'd3);
    step(); chk("R11 before match", ocfB, 0);
    step(); chk("R11 at match cnt", cntOut, 5); chk("R11 match pulse", ocfB, 1);
    chk("R12 toggle up", ocBOut, 1);
    step(); chk("R11 pulse ends", ocfB, 0); chk("R12 holds", ocBOut, 1);
    wr(2, 16'd5);
    chk("R10 write no match", ocfB, 0); chk("R10 wave unchanged", ocBOut, 1);
    wr(2, 16'd4);
    step(); chk("R12 toggle down", ocBOut, 0);
    wr(1, 16'h00); wr(0, 16'h00);
    chk("R12 mode0 low", ocBOut, 0);
  endtask

  task automatic t_ctc();
    wr(0, 16'h00); wr(1, 16'h08); wr(3, 16'd3); wr(1, 16'h09); wr(2, 16'd0);
    step(); step(); chk("R5 count", cntOut, 2);
    step(); chk("R5 at top", cntOut, 3); chk("R5 ocfA", ocfA, 1);
    step(); chk("R5 clear", cntOut, 0); chk("R5 no ovf", tovPulse, 0);
    chk("R5 ocfA one cycle", ocfA, 0);
    step(); chk("R5 restart", cntOut, 1);
  endtask

  task automatic t_fast();
    wr(1, 16'h00); wr(0, 16'h00); wr(3, 16'h10);
    wr(0, 16'h81); wr(1, 16'h09); wr(2, 16'hFD);
    chk("R6 wave start", ocAOut, 0);
    step(); step(); chk("R6 at ff", cntOut, 16'hFF);
    step(); chk("R6 wrap", cntOut, 0); chk("R6 ovf", tovPulse, 1);
    chk("R6 set at bottom", ocAOut, 1);
    repeat (15) step();
    chk("R6 before match", ocAOut, 1);
    step(); chk("R6 match cnt", cntOut, 16'h10); chk("R6 ocfA", ocfA, 1);
    chk("R6 clear on match", ocAOut, 0);
  endtask

  task automatic t_dual();
    wr(1, 16'h00); wr(0, 16'h01); wr(1, 16'h01); wr(2, 16'hFE);
    step(); chk("R7 at top", cntOut, 16'hFF); chk("R7 no ovf at top", tovPulse, 0);
    step(); chk("R7 turn down", cntOut, 16'hFE);
    runTo(16'h0, 300);
    chk("R7 reach 0", cntOut, 0); chk("R7 no ovf arriving 0", tovPulse, 0);
    step(); chk("R7 turn up", cntOut, 1); chk("R7 ovf at bottom", tovPulse, 1);
  endtask

  task automatic t_buf();
    wr(3, 16'h20); wr(2, 16'h0E);
    step(); step(); chk("R8 cnt", cntOut, 16'h10); chk("R8 old value matches", ocfA, 1);
    runTo(16'h20, 40);
    chk("R8 new value not yet", ocfA, 0);
    runTo(16'hFF, 300);
    step();
    runTo(16'h20, 300);
    chk("R8 new value after top", ocfA, 1);
  endtask

  task automatic t_icr();
    wr(1, 16'h00); wr(0, 16'h00); wr(5, 16'd2); wr(1, 16'h19); wr(2, 16'd0);
    step(); step(); chk("R9 at cap", cntOut, 2);
    step(); chk("R9 clear", cntOut, 0);
    step(); chk("R9 restart", cntOut, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChk++; nFail++;
    $display("FAIL watchdog act=running exp=finished");
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    repeat (3) step();
    t_reset();
    rstN = 1'b1;
    repeat (3) step();
    t_reset();
    t_stop();
    t_presc();
    t_normal();
    t_chanB();
    t_ctc();
    t_fast();
    t_dual();
    t_buf();
    t_icr();
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule